// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block produces the write address for a display memory that is 64 byte-columns wide and 80 rows deep. Each byte carries two 4-bit grey-level pixels. Commands load a column window and a row window, each as a start and an end value. Loading a window also moves the matching pointer to its start value. From then on, every data byte written advances the pointers through the rectangle that the two windows bound, and wraps back to the rectangle's corner when it runs off the far side.

Two mode bits are held in a small register. One bit chooses the stepping order. In the horizontal order the column moves first and the row moves at the end of each line. In the vertical order the row moves first and the column moves at the bottom of each column strip. The other bit swaps the two pixel nibbles of each byte before the byte reaches the memory.

Each data byte that arrives on the write strobe is issued one cycle later as a registered memory write. The write carries the pointer position that was current when the byte arrived, and the data in nibble-corrected form.

Top module: `dispAddrGen`

## Requirements
- R1: After reset both pointers, all four window bounds and both mode bits are 0 (horizontal order, no nibble swap), and `ramWe` is 0.
- R2: A cycle with `colLoad` high stores `colStartIn` and `colEndIn` as the column window, and `ptrCol` equals `colStartIn` after that edge.
- R3: A cycle with `rowLoad` high stores `rowStartIn` and `rowEndIn` as the row window, and `ptrRow` equals `rowStartIn` after that edge.
- R4: In horizontal order (vertical bit 0), a write moves the column up by one. If the column was already at or beyond the column end, the column returns to the column start and the row steps instead.
- R5: A row step moves the row up by one. If the row was already at or beyond the row end, or at the last physical row 79, the row returns to the row start.
- R6: In vertical order (vertical bit 1), a write steps the row as in R5. When that step wraps the row, the column also steps: it goes up by one, or returns to the column start if it was at or beyond the column end.
- R7: Exactly one cycle after each `wrStrobe`, `ramWe` is 1 for one cycle, and `ramCol`/`ramRow` hold the pointer as it was when the strobe arrived. `ramWe` is 0 in cycles that do not follow a strobe.
- R8: `wrData[3:0]` is the pixel of even column 2n and `wrData[7:4]` the pixel of column 2n+1. With the swap bit 0, `ramData` equals `wrData`. With the swap bit 1, `ramData` is `{wrData[3:0], wrData[7:4]}`.
- R9: A write in the same cycle as a column or row load is still issued at the old pointer. Neither pointer advances, and the loaded pointer takes its start value.
- R10: With a window start above its end, that axis returns to its start on every step, so the pointer stays at the start value.
- R11: A mode load (`modeLoad`) takes effect for writes in later cycles. A write in the same cycle still uses the previous mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colLoad | input | 1 | Load column window and column pointer |
| colStartIn | input | 6 | Column window start |
| colEndIn | input | 6 | Column window end |
| rowLoad | input | 1 | Load row window and row pointer |
| rowStartIn | input | 7 | Row window start (0 to 79) |
| rowEndIn | input | 7 | Row window end |
| modeLoad | input | 1 | Load the two mode bits |
| vertIn | input | 1 | Stepping order: 1 vertical, 0 horizontal |
| swapIn | input | 1 | Nibble swap enable |
| wrStrobe | input | 1 | One data byte arrives |
| wrData | input | 8 | Data byte, two pixels |
| ptrCol | output | 6 | Current column pointer |
| ptrRow | output | 7 | Current row pointer |
| ramWe | output | 1 | Memory write enable |
| ramCol | output | 6 | Memory write column |
| ramRow | output | 7 | Memory write row |
| ramData | output | 8 | Memory write data |

## Verification
The row range assertion assumes that `rowStartIn` never exceeds 79. The block does not clamp the start value, although an end value above 79 is legal because the row wraps at the last physical row anyway. The random stimulus draws row starts only from 0 to 79 and row ends from the full 7-bit range, so the physical-row wrap is exercised. Column values may be any 6-bit value, and window loads land freely on top of writes and mode changes.

// File: rtl/dispAddrPkg.sv
`timescale 1ns/1ps
package dispAddrPkg;
  // Strobes from the control to the datapath, valid in the current cycle
  typedef struct packed {
    logic colStep;  // advance or wrap the column pointer
    logic rowStep;  // advance or wrap the row pointer
    logic issue;    // register a memory write this edge
    logic swap;     // exchange pixel nibbles of the issued byte
  } stepCtl_t;
endpackage

// File: rtl/dispAxisPtr.sv
`timescale 1ns/1ps
module dispAxisPtr #(
  parameter int PTR_W = 6,
  parameter int LIMIT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [PTR_W-1:0] startIn,
  input  logic [PTR_W-1:0] endIn,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic             atEnd
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(LIMIT - 1);

  logic [PTR_W-1:0] startReg, endReg, ptrReg;

  // Wrap when at or past the window end, or on the last physical line
  assign atEnd = (ptrReg >= endReg) || (ptrReg == TOP);
  assign ptr   = ptrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      endReg   <= '0;
      ptrReg   <= '0;
    end else if (load) begin
      startReg <= startIn;
      endReg   <= endIn;
      ptrReg   <= startIn;
    end else if (step) begin
      ptrReg <= atEnd ? startReg : ptrReg + 1'b1;
    end
  end

  AST_LOAD_SETS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    load |=> ptr == $past(startIn));                                  // R2
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && atEnd) |=> ptr == startReg);                    // R5
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && !atEnd) |=> ptr == $past(ptr) + 1'b1);          // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !load) |=> $stable(ptr));                               // R9
endmodule

// File: rtl/dispAddrCtl.sv
`timescale 1ns/1ps
module dispAddrCtl
  import dispAddrPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeLoad,
  input  logic     vertIn,
  input  logic     swapIn,
  input  logic     wrStrobe,
  input  logic     colLoad,
  input  logic     rowLoad,
  input  logic     colAtEnd,
  input  logic     rowAtEnd,
  output stepCtl_t ctl
);
  logic vertMode, swapMode, advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vertMode <= 1'b0;
      swapMode <= 1'b0;
    end else if (modeLoad) begin
      vertMode <= vertIn;
      swapMode <= swapIn;
    end
  end

  // A window load in the same cycle freezes both pointers
  assign advance = wrStrobe && !colLoad && !rowLoad;

  always_comb begin
    ctl.issue = wrStrobe;
    ctl.swap  = swapMode;
    if (vertMode) begin
      ctl.rowStep = advance;
      ctl.colStep = advance && rowAtEnd;
    end else begin
      ctl.colStep = advance;
      ctl.rowStep = advance && colAtEnd;
    end
  end

  AST_HORIZ_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!vertMode && ctl.rowStep) |-> (ctl.colStep && colAtEnd));       // R4
  AST_VERT_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (vertMode && ctl.colStep) |-> (ctl.rowStep && rowAtEnd));        // R6
  AST_LOAD_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (colLoad || rowLoad) |-> (!ctl.colStep && !ctl.rowStep));        // R9
endmodule

// File: rtl/dispAddrPath.sv
`timescale 1ns/1ps
module dispAddrPath
  import dispAddrPkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 80,
  parameter int PIX_W = 4,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int DATA_W = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic              colLoad,
  input  logic [COL_W-1:0]  colStartIn,
  input  logic [COL_W-1:0]  colEndIn,
  input  logic              rowLoad,
  input  logic [ROW_W-1:0]  rowStartIn,
  input  logic [ROW_W-1:0]  rowEndIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [COL_W-1:0]  colPtr,
  output logic [ROW_W-1:0]  rowPtr,
  output logic              colAtEnd,
  output logic              rowAtEnd,
  output logic              ramWe,
  output logic [COL_W-1:0]  ramCol,
  output logic [ROW_W-1:0]  ramRow,
  output logic [DATA_W-1:0] ramData
);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);

  logic [DATA_W-1:0] swapped;

  dispAxisPtr #(.PTR_W(COL_W), .LIMIT(COLS)) u_colAxis (
    .clk(clk), .rstN(rstN), .load(colLoad), .startIn(colStartIn),
    .endIn(colEndIn), .step(ctl.colStep), .ptr(colPtr), .atEnd(colAtEnd));

  dispAxisPtr #(.PTR_W(ROW_W), .LIMIT(ROWS)) u_rowAxis (
    .clk(clk), .rstN(rstN), .load(rowLoad), .startIn(rowStartIn),
    .endIn(rowEndIn), .step(ctl.rowStep), .ptr(rowPtr), .atEnd(rowAtEnd));

  assign swapped = {dataIn[PIX_W-1:0], dataIn[DATA_W-1:PIX_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramCol  <= '0;
      ramRow  <= '0;
      ramData <= '0;
    end else begin
      ramWe <= ctl.issue;
      if (ctl.issue) begin
        ramCol  <= colPtr;
        ramRow  <= rowPtr;
        ramData <= ctl.swap ? swapped : dataIn;
      end
    end
  end

  AST_WE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> ramWe);                                             // R7
  AST_WE_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.issue |=> !ramWe);                                           // R7
  AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> (ramCol == $past(colPtr)) && (ramRow == $past(rowPtr))); // R7
  AST_NIBBLE_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && ctl.swap) |=> ramData[PIX_W-1:0] == $past(dataIn[DATA_W-1:PIX_W])); // R8
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rowPtr <= ROW_TOP);                                               // R5
endmodule

// File: rtl/dispAddrGen.sv
`timescale 1ns/1ps
module dispAddrGen
  import dispAddrPkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 80,
  parameter int PIX_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       colLoad,
  input  logic [$clog2(COLS)-1:0]    colStartIn,
  input  logic [$clog2(COLS)-1:0]    colEndIn,
  input  logic                       rowLoad,
  input  logic [$clog2(ROWS)-1:0]    rowStartIn,
  input  logic [$clog2(ROWS)-1:0]    rowEndIn,
  input  logic                       modeLoad,
  input  logic                       vertIn,
  input  logic                       swapIn,
  input  logic                       wrStrobe,
  input  logic [2*PIX_W-1:0]         wrData,
  output logic [$clog2(COLS)-1:0]    ptrCol,
  output logic [$clog2(ROWS)-1:0]    ptrRow,
  output logic                       ramWe,
  output logic [$clog2(COLS)-1:0]    ramCol,
  output logic [$clog2(ROWS)-1:0]    ramRow,
  output logic [2*PIX_W-1:0]         ramData
);
  stepCtl_t ctl;
  logic colAtEnd, rowAtEnd;

  dispAddrCtl u_ctl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .vertIn(vertIn),
    .swapIn(swapIn), .wrStrobe(wrStrobe), .colLoad(colLoad),
    .rowLoad(rowLoad), .colAtEnd(colAtEnd), .rowAtEnd(rowAtEnd), .ctl(ctl));

  dispAddrPath #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .colLoad(colLoad), .colStartIn(colStartIn), .colEndIn(colEndIn),
    .rowLoad(rowLoad), .rowStartIn(rowStartIn), .rowEndIn(rowEndIn),
    .dataIn(wrData), .colPtr(ptrCol), .rowPtr(ptrRow),
    .colAtEnd(colAtEnd), .rowAtEnd(rowAtEnd),
    .ramWe(ramWe), .ramCol(ramCol), .ramRow(ramRow), .ramData(ramData));
endmodule

// File: tb/dispAddrGen_tb.sv
`timescale 1ns/1ps
module dispAddrGen_tb;
  localparam int COLS = 64;
  localparam int ROWS = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic colLoad = 0, rowLoad = 0, modeLoad = 0, vertIn = 0, swapIn = 0, wrStrobe = 0;
  logic [5:0] colStartIn = 0, colEndIn = 0;
  logic [6:0] rowStartIn = 0, rowEndIn = 0;
  logic [7:0] wrData = 0;
  logic [5:0] ptrCol, ramCol;
  logic [6:0] ptrRow, ramRow;
  logic ramWe;
  logic [7:0] ramData;

  always #5 clk = ~clk;

  dispAddrGen u_dut (
    .clk(clk), .rstN(rstN), .colLoad(colLoad), .colStartIn(colStartIn),
    .colEndIn(colEndIn), .rowLoad(rowLoad), .rowStartIn(rowStartIn),
    .rowEndIn(rowEndIn), .modeLoad(modeLoad), .vertIn(vertIn), .swapIn(swapIn),
    .wrStrobe(wrStrobe), .wrData(wrData), .ptrCol(ptrCol), .ptrRow(ptrRow),
    .ramWe(ramWe), .ramCol(ramCol), .ramRow(ramRow), .ramData(ramData));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench model of the pointer state
  int mCol = 0, mRow = 0, mColS = 0, mColE = 0, mRowS = 0, mRowE = 0;
  bit mVert = 0, mSwap = 0;
  bit eWe = 0;
  int eCol = 0, eRow = 0, eData = 0;

  function automatic bit axisEnd(int p, int e, int top);
    return (p >= e) || (p == top);
  endfunction

  function automatic int nibSwap(int d, bit s);
    return s ? (((d & 15) << 4) | ((d >> 4) & 15)) : (d & 255);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, update the model, sample at next negedge
  task automatic step(bit cl, int cs, int ce, bit rl, int rs, int re,
                      bit ml, bit mv, bit msw, bit wr, int d, string req);
    bit cEnd, rEnd;
    colLoad = cl; colStartIn = 6'(cs); colEndIn = 6'(ce);
    rowLoad = rl; rowStartIn = 7'(rs); rowEndIn = 7'(re);
    modeLoad = ml; vertIn = mv; swapIn = msw;
    wrStrobe = wr; wrData = 8'(d);
    eWe = wr;
    if (wr) begin
      eCol = mCol; eRow = mRow; eData = nibSwap(d, mSwap);
    end
    if (wr && !cl && !rl) begin
      cEnd = axisEnd(mCol, mColE, COLS - 1);
      rEnd = axisEnd(mRow, mRowE, ROWS - 1);
      if (!mVert) begin
        if (cEnd) begin mCol = mColS; mRow = rEnd ? mRowS : mRow + 1; end
        else mCol = mCol + 1;
      end else begin
        if (rEnd) begin mRow = mRowS; mCol = cEnd ? mColS : mCol + 1; end
        else mRow = mRow + 1;
      end
    end
    if (cl) begin mColS = cs & 63; mColE = ce & 63; mCol = mColS; end
    if (rl) begin mRowS = rs & 127; mRowE = re & 127; mRow = mRowS; end
    if (ml) begin mVert = mv; mSwap = msw; end
    @(negedge clk);
    colLoad = 0; rowLoad = 0; modeLoad = 0; wrStrobe = 0;
    check(req, "ramWe", int'(ramWe), int'(eWe));
    if (eWe) begin
      check(req, "ramCol", int'(ramCol), eCol);
      check(req, "ramRow", int'(ramRow), eRow);
      check(req, "ramData", int'(ramData), eData);
    end
    check(req, "ptrCol", int'(ptrCol), mCol);
    check(req, "ptrRow", int'(ptrRow), mRow);
  endtask

  task automatic wr(int d, string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d, req);
  endtask
  task automatic setCol(int s, int e, string req);
    step(1, s, e, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic setRow(int s, int e, string req);
    step(0, 0, 0, 1, s, e, 0, 0, 0, 0, 0, req);
  endtask
  task automatic setMode(bit v, bit s, string req);
    step(0, 0, 0, 0, 0, 0, 1, v, s, 0, 0, req);
  endtask
  task automatic idle(string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "ptrCol", int'(ptrCol), 0);
    check("R1", "ptrRow", int'(ptrRow), 0);
    check("R1", "ramWe", int'(ramWe), 0);
    wr(8'h12, "R1");   // default 0..0 windows keep the pointer at the origin
    idle("R7");        // no strobe, no write

    // R2 R3: window loads
    setCol(2, 4, "R2");
    setRow(5, 6, "R3");
    // R4: horizontal stepping across two lines and a row wrap
    for (int i = 0; i < 7; i++) wr(i + 16, "R4");

    // R5: row wraps at the last physical row even with a larger end
    setCol(0, 0, "R2");
    setRow(78, 127, "R5");
    for (int i = 0; i < 4; i++) wr(i, "R5");

    // R6: vertical order
    setMode(1, 0, "R6");
    setCol(10, 11, "R2");
    setRow(3, 5, "R3");
    for (int i = 0; i < 7; i++) wr(i + 32, "R6");

    // R8: nibble positions with and without swap
    setMode(0, 1, "R8");
    wr(8'hA5, "R8");
    setMode(0, 0, "R8");
    wr(8'h3C, "R8");

    // R11: mode load together with a write uses the old mode
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 8'h81, "R11");
    wr(8'h81, "R11");
    setMode(0, 0, "R11");

    // R9: load together with a write
    setCol(20, 30, "R9");
    wr(1, "R9");
    step(1, 40, 50, 0, 0, 0, 0, 0, 0, 1, 8'h77, "R9");
    step(0, 0, 0, 1, 12, 20, 0, 0, 0, 1, 8'h66, "R9");

    // R10: start above end keeps the column at its start
    setCol(9, 3, "R10");
    setRow(0, 7, "R10");
    for (int i = 0; i < 4; i++) wr(i, "R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 19);
      case (r)
        0: setCol($urandom_range(0, 63), $urandom_range(0, 63), "R2");
        1: setRow($urandom_range(0, 79), $urandom_range(0, 127), "R3");
        2: setMode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R11");
        3: idle("R7");
        4: step(1, $urandom_range(0, 63), $urandom_range(0, 63), 0, 0, 0,
                0, 0, 0, 1, $urandom_range(0, 255), "R9");
        default: wr($urandom_range(0, 255), "R4");
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule